// File: doc/BRIEF.md
# Parallel CISC Instruction Length Decoder

This block finds the byte length of a single variable-length instruction sitting at the start of a 16-byte fetch window. The encoding is orthogonal: a one-byte opcode is followed by between zero and six operand specifiers, and each specifier's size depends on its own addressing mode. A front end uses the result to decide where the next instruction begins and where each operand specifier starts.

Every byte position in the window is decoded at the same time, as though an operand specifier began there, giving a candidate size per position. A small opcode table, supplied as an input, gives the operand count and the immediate data size for the opcode. A chaining stage then starts at offset 1 and hops from one real specifier to the next by the candidate size found at each stop. The sum is the length. A window too short for the instruction, or an opcode without a usable table entry, raises an overflow flag so that the fetch logic can retry with more bytes. A malformed index prefix raises a fault flag.

Top module: `ild_top`

## Requirements
- R1: The opcode is byte 0 of the window, and the first specifier starts at offset 1. Slot k of `specOffs` (bits 4k+3..4k) holds the start offset of specifier k. Slots at or above the operand count read 0.
- R2: The opcode table holds 16 entries of 6 bits. Entry i sits at bits 6i+5..6i and is indexed by opcode bits 3..0. In each entry, bit 5 is valid, bits 4..2 are the operand count, and bits 1..0 are the data size code. Overflow is raised when the entry is not valid, when its count exceeds 6, or when opcode bits 7..4 are not zero.
- R3: A specifier byte holds its mode in bits 7..4 and its register in bits 3..0. Modes 0 to 3, 5, 6 and 7 are 1 byte long. Modes 8 and 9 are also 1 byte unless the register is 15. Modes A and B are 2 bytes, modes C and D are 3 bytes, and modes E and F are 5 bytes.
- R4: Mode 8 with register 15 is an immediate. Its length is 1 plus the data size, and data size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R5: Mode 9 with register 15 is an absolute address and is 5 bytes long.
- R6: Mode 4 is an index prefix. Its length is 1 plus the length of the base specifier in the following byte.
- R7: An index prefix whose base has mode 0 to 5 (a literal, another index prefix, or register mode) raises `fault`.
- R8: When the instruction extends beyond byte 15 of the window, `overflow` is raised. A length of exactly 16 is legal.
- R9: Results and `done` appear one clock after a cycle with `winValid` high. `done` is low after any cycle with `winValid` low, and the result outputs hold their values.
- R10: After reset, `done`, `overflow`, `fault`, `lenOut` and `specOffs` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| winValid | input | 1 | Window and table are valid this cycle |
| winBytes | input | 128 | Fetch window; byte i at bits 8i+7..8i |
| opTable | input | 96 | Opcode table, 16 entries of 6 bits |
| lenOut | output | 5 | Instruction length in bytes |
| specOffs | output | 24 | Six 4-bit specifier start offsets |
| done | output | 1 | Result valid this cycle |
| overflow | output | 1 | Instruction exceeds window, or opcode unusable |
| fault | output | 1 | Malformed index prefix found |

## Verification
On every cycle the assertions check that `done` follows `winValid` by exactly one clock, that results hold between loads, that a bad table entry always yields overflow, that every non-overflow length lies in 1..16, and that the first offset is 1. Whether the sizes are right for each addressing mode, whether the PC-relative immediate and absolute forms are handled, how index prefixes nest, and where the 16/17-byte boundary falls can only be shown by the bench's scenarios. For these, the bench compares the outputs against an independent sequential walk, over directed encodings and randomised specifier streams.

// File: rtl/ild_pkg.sv
package ild_pkg;

  typedef struct packed {
    logic load;
  } ildStrobe_t;

  typedef struct packed {
    logic       ok;
    logic [2:0] cnt;
    logic [1:0] szCode;
  } tblEntry_t;

  localparam logic [3:0] MODE_INDEX = 4'h4;
  localparam logic [3:0] REG_PC     = 4'hF;

  // Size of a non-prefixed specifier starting with byte b
  function automatic logic [3:0] baseSize(input logic [7:0] b, input logic [3:0] dsz);
    logic [3:0] md;
    md = b[7:4];
    case (md)
      4'h8:        baseSize = (b[3:0] == REG_PC) ? 4'd1 + dsz : 4'd1;
      4'h9:        baseSize = (b[3:0] == REG_PC) ? 4'd5 : 4'd1;
      4'hA, 4'hB:  baseSize = 4'd2;
      4'hC, 4'hD:  baseSize = 4'd3;
      4'hE, 4'hF:  baseSize = 4'd5;
      default:     baseSize = 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/ild_ctrl.sv
module ild_ctrl
  import ild_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       winValid,
  output ildStrobe_t strobe,
  output logic       done
);

  always_comb begin
    strobe.load = winValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= winValid;
  end

  AST_DONE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    winValid |=> done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !winValid |=> !done); // R9

endmodule

// File: rtl/ild_dp.sv
module ild_dp
  import ild_pkg::*;
#(
  parameter int WIN_BYTES = 16,
  parameter int MAX_SPEC  = 6,
  parameter int TBL_AW    = 4,
  localparam int TBL_N    = 1 << TBL_AW,
  localparam int ENT_W    = $bits(tblEntry_t),
  localparam int OFF_W    = $clog2(WIN_BYTES),
  localparam int LEN_W    = $clog2(WIN_BYTES + 1),
  localparam int POS_W    = $clog2(WIN_BYTES + MAX_SPEC * 10 + 1)
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  ildStrobe_t                strobe,
  input  logic [WIN_BYTES*8-1:0]    window,
  input  logic [TBL_N*ENT_W-1:0]    opTable,
  output logic [LEN_W-1:0]          lenOut,
  output logic [MAX_SPEC*OFF_W-1:0] offsOut,
  output logic                      ovfOut,
  output logic                      faultOut
);

  // Opcode table lookup
  tblEntry_t tblArr [TBL_N];
  for (genvar i = 0; i < TBL_N; i++) begin : g_tbl
    assign tblArr[i] = tblEntry_t'(opTable[i*ENT_W +: ENT_W]);
  end

  logic [7:0]        opcode;
  logic [TBL_AW-1:0] opIdx;
  logic              opHighSet;
  tblEntry_t         entry;
  logic              tblBad;
  logic [3:0]        dsz;

  assign opcode    = window[7:0];
  assign opIdx     = opcode[TBL_AW-1:0];
  assign opHighSet = (TBL_AW < 8) ? ((opcode >> TBL_AW) != 8'd0) : 1'b0;
  assign entry     = tblArr[opIdx];
  assign tblBad    = !entry.ok || (int'(entry.cnt) > MAX_SPEC) || opHighSet;
  assign dsz       = 4'd1 << entry.szCode;

  // Speculative decode: every position treated as a specifier start
  logic [3:0] specSize [WIN_BYTES];
  logic       specBad  [WIN_BYTES];

  for (genvar p = 0; p < WIN_BYTES; p++) begin : g_pos
    logic [7:0] cur;
    logic       isIdx;
    assign cur   = window[p*8 +: 8];
    assign isIdx = (cur[7:4] == MODE_INDEX);
    if (p + 1 < WIN_BYTES) begin : g_in
      logic [7:0] nxt;
      assign nxt         = window[(p+1)*8 +: 8];
      assign specSize[p] = isIdx ? 4'd1 + baseSize(nxt, dsz) : baseSize(cur, dsz);
      assign specBad[p]  = isIdx && (nxt[7:4] <= 4'h5);
    end else begin : g_edge
      // Base lies outside the window: minimum size pushes into overflow
      assign specSize[p] = isIdx ? 4'd2 : baseSize(cur, dsz);
      assign specBad[p]  = 1'b0;
    end
  end

  // Chain walk from offset 1 through the real specifiers
  logic [POS_W-1:0]          pos;
  logic [MAX_SPEC*OFF_W-1:0] offsNext;
  logic                      faultNext;
  logic                      ovfNext;

  always_comb begin
    pos       = POS_W'(1);
    offsNext  = '0;
    faultNext = 1'b0;
    for (int k = 0; k < MAX_SPEC; k++) begin
      if (k < int'(entry.cnt)) begin
        offsNext[k*OFF_W +: OFF_W] = pos[OFF_W-1:0];
        if (pos < POS_W'(WIN_BYTES)) begin
          faultNext = faultNext | specBad[pos[OFF_W-1:0]];
          pos       = pos + POS_W'(specSize[pos[OFF_W-1:0]]);
        end else begin
          pos = pos + POS_W'(1);
        end
      end
    end
    ovfNext = tblBad || (pos > POS_W'(WIN_BYTES));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenOut   <= '0;
      offsOut  <= '0;
      ovfOut   <= 1'b0;
      faultOut <= 1'b0;
    end else if (strobe.load) begin
      lenOut   <= pos[LEN_W-1:0];
      offsOut  <= offsNext;
      ovfOut   <= ovfNext;
      faultOut <= faultNext;
    end
  end

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (ovfOut || (lenOut != '0 && int'(lenOut) <= WIN_BYTES))); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(lenOut) && $stable(ovfOut) && $stable(faultOut) && $stable(offsOut))); // R9
  AST_TBL_BAD_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && tblBad) |=> ovfOut); // R2
  AST_FIRST_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !tblBad && entry.cnt != 3'd0) |=> (offsOut[OFF_W-1:0] == OFF_W'(1))); // R1

endmodule

// File: rtl/ild_top.sv
module ild_top
  import ild_pkg::*;
#(
  parameter int WIN_BYTES = 16,
  parameter int MAX_SPEC  = 6,
  parameter int TBL_AW    = 4,
  localparam int TBL_N    = 1 << TBL_AW,
  localparam int ENT_W    = $bits(tblEntry_t),
  localparam int OFF_W    = $clog2(WIN_BYTES),
  localparam int LEN_W    = $clog2(WIN_BYTES + 1)
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      winValid,
  input  logic [WIN_BYTES*8-1:0]    winBytes,
  input  logic [TBL_N*ENT_W-1:0]    opTable,
  output logic [LEN_W-1:0]          lenOut,
  output logic [MAX_SPEC*OFF_W-1:0] specOffs,
  output logic                      done,
  output logic                      overflow,
  output logic                      fault
);

  ildStrobe_t strobe;

  ild_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .winValid (winValid),
    .strobe   (strobe),
    .done     (done)
  );

  ild_dp #(
    .WIN_BYTES (WIN_BYTES),
    .MAX_SPEC  (MAX_SPEC),
    .TBL_AW    (TBL_AW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .window   (winBytes),
    .opTable  (opTable),
    .lenOut   (lenOut),
    .offsOut  (specOffs),
    .ovfOut   (overflow),
    .faultOut (fault)
  );

endmodule

// File: tb/tb_ild_top.sv
module tb_ild_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          len;
    bit          ovf;
    bit          flt;
    logic [23:0] offs;
    string       tag;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         winValid = 1'b0;
  logic [127:0] winBytes = '0;
  logic [95:0]  opTable;
  logic [4:0]   lenOut;
  logic [23:0]  specOffs;
  logic         done, overflow, fault;

  int total = 0;
  int bad   = 0;
  expItem_t expQ[$];
  logic [7:0] w [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  ild_top dut (
    .clk(clk), .rstN(rstN), .winValid(winValid), .winBytes(winBytes),
    .opTable(opTable), .lenOut(lenOut), .specOffs(specOffs),
    .done(done), .overflow(overflow), .fault(fault)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Reference sizes written from the requirements
  function automatic int refSize(input logic [7:0] b, input int dbytes);
    int m, r;
    m = int'(b[7:4]);
    r = int'(b[3:0]);
    if (m >= 14) return 5;
    if (m >= 12) return 3;
    if (m >= 10) return 2;
    if (m == 9) return (r == 15) ? 5 : 1;
    if (m == 8) return (r == 15) ? 1 + dbytes : 1;
    return 1;
  endfunction

  function automatic expItem_t refWalk(input string tag);
    expItem_t e;
    int op, cnt, sc, dbytes, pos, sz;
    bit ok;
    e.tag = tag; e.offs = '0; e.flt = 0; e.ovf = 0;
    op  = int'(w[0]);
    ok  = opTable[(op%16)*6 + 5];
    cnt = int'(opTable[(op%16)*6 + 2 +: 3]);
    sc  = int'(opTable[(op%16)*6 +: 2]);
    dbytes = (sc == 0) ? 1 : (sc == 1) ? 2 : (sc == 2) ? 4 : 8;
    if (!ok || cnt > 6 || op >= 16) begin
      e.ovf = 1; e.len = 0; return e;
    end
    pos = 1;
    for (int k = 0; k < cnt; k++) begin
      e.offs[k*4 +: 4] = 4'(pos);
      if (pos >= 16) begin pos = pos + 1; continue; end
      if (w[pos][7:4] == 4'h4) begin
        if (pos + 1 >= 16) sz = 2;
        else begin
          if (int'(w[pos+1][7:4]) <= 5) e.flt = 1;
          sz = 1 + refSize(w[pos+1], dbytes);
        end
      end else sz = refSize(w[pos], dbytes);
      pos = pos + sz;
    end
    e.len = pos;
    e.ovf = (pos > 16);
    return e;
  endfunction

  task automatic drive(input string tag);
    expItem_t e;
    @(posedge clk); #1;
    for (int i = 0; i < 16; i++) winBytes[i*8 +: 8] = w[i];
    winValid = 1'b1;
    e = refWalk(tag);
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    winValid = 1'b0;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic setWin(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7,
                        b8, b9, b10, b11, b12, b13, b14, b15);
    w[0]=b0; w[1]=b1; w[2]=b2; w[3]=b3; w[4]=b4; w[5]=b5; w[6]=b6; w[7]=b7;
    w[8]=b8; w[9]=b9; w[10]=b10; w[11]=b11; w[12]=b12; w[13]=b13; w[14]=b14; w[15]=b15;
  endtask

  // Scoreboard monitor
  initial begin
    expItem_t e;
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        if (expQ.size() == 0) check(0, "R9 unexpected done", 1, 0);
        else begin
          e = expQ.pop_front();
          check(overflow == e.ovf, {"R8/R2 overflow ", e.tag}, overflow, e.ovf);
          if (!e.ovf) check(fault == e.flt, {"R7 fault ", e.tag}, fault, e.flt);
          if (!e.ovf && !e.flt) begin
            check(int'(lenOut) == e.len, {"R3 length ", e.tag}, lenOut, e.len);
            check(specOffs == e.offs, {"R1 offsets ", e.tag}, specOffs, e.offs);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Table: entry i = ok, count i%7, size code i%4; 7 invalid; 15 count 7
    for (int i = 0; i < 16; i++)
      opTable[i*6 +: 6] = {1'b1, 3'(i % 7), 2'(i % 4)};
    opTable[7*6 +: 6]  = {1'b0, 3'd1, 2'd0};
    opTable[15*6 +: 6] = {1'b1, 3'd7, 2'd0};

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(done == 0 && overflow == 0 && fault == 0, "R10 reset flags", {done, overflow, fault}, 0);
    check(lenOut == 0 && specOffs == 0, "R10 reset data", lenOut, 0);
    @(posedge clk); #1 rstN = 1'b1;

    // R3 R6: three-operand form, length 7
    setWin(8'h03,8'h51,8'hC2,8'hE1,8'h02,8'h44,8'h63,8'h00,
           8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00);
    drive("R6 example");
    idle(4);
    @(negedge clk);
    check(done == 0, "R9 done low when idle", done, 0);
    check(lenOut == 5'd7, "R9 length held", lenOut, 7);

    // R4: immediate, 8-byte data, then three 1-byte specifiers
    setWin(8'h0B,8'h8F,8'h11,8'h22,8'h33,8'h44,8'h55,8'h66,
           8'h77,8'h88,8'h50,8'h60,8'h70,8'h00,8'h00,8'h00);
    drive("R4 imm8");
    // R4: immediate with 2-byte data
    setWin(8'h01,8'h8F,8'hAA,8'hBB,8'h00,8'h00,8'h00,8'h00,
           8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00);
    drive("R4 imm2");
    // R5: absolute
    setWin(8'h01,8'h9F,8'h01,8'h02,8'h03,8'h04,8'h00,8'h00,
           8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00);
    drive("R5 absolute");
    // R7: index on register, index on index
    setWin(8'h01,8'h45,8'h52,8'h00,8'h00,8'h00,8'h00,8'h00,
           8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00);
    drive("R7 idx on reg");
    setWin(8'h01,8'h44,8'h41,8'h61,8'h00,8'h00,8'h00,8'h00,
           8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00);
    drive("R7 idx on idx");
    // R6: index on displacement
    setWin(8'h01,8'h43,8'hA2,8'h10,8'h00,8'h00,8'h00,8'h00,
           8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00);
    drive("R6 idx disp");
    // R8: exactly 16, then 17
    setWin(8'h03,8'hE0,8'h00,8'h00,8'h00,8'h00,8'hE1,8'h00,
           8'h00,8'h00,8'h00,8'hE2,8'h00,8'h00,8'h00,8'h00);
    drive("R8 len16");
    setWin(8'h04,8'hE0,8'h00,8'h00,8'h00,8'h00,8'hE1,8'h00,
           8'h00,8'h00,8'h00,8'hE2,8'h00,8'h00,8'h00,8'h00);
    drive("R8 len17");
    // R2: invalid entry, count 7, high opcode bits
    setWin(8'h07,8'h50,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,
           8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00);
    drive("R2 invalid");
    w[0] = 8'h0F; drive("R2 count7");
    w[0] = 8'h21; drive("R2 high bits");
    // R1: zero operands
    w[0] = 8'h00; drive("R1 zero ops");
    idle(3);

    // Randomised streams, some back-to-back
    for (int t = 0; t < 400; t++) begin
      for (int i = 0; i < 16; i++) w[i] = 8'($urandom);
      w[0] = ($urandom % 10 == 0) ? 8'($urandom) : 8'($urandom % 16);
      drive("random");
      if ($urandom % 3 == 0) idle(2);
    end
    idle(4);
    check(expQ.size() == 0, "R9 all results seen", expQ.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule